// File: doc/BRIEF.md
# Frequent-Value Encoded Word Store

This block is the data array of a small data cache in which most words equal one of a few common values. A programmable table of up to 32 such values sits beside the array. When a word is written, it is compared against every valid table entry. A word that matches is kept only as its table index in a 5-bit low slice, and a per-word flag is cleared. A word that matches nothing is kept whole, across the low slice and a 27-bit high slice, with the flag set.

On a read, the flag decides the path. A frequent word is expanded through the table. Any other word is reassembled from its two slices. Both paths take exactly one cycle. For every word held in encoded form, the block drives a gate-enable bit that can remove the supply from that word's idle high slice. A counter reports how many words are currently gated.

The table is loaded through its own write port before a program starts. An input then locks the table for the length of the run. Setting the parameter `NUM_FV` to 16 gives a reduced table with 4-bit codes.

Top module: `fv_word_store`

## Requirements
- R1: After reset every word reads as 0x00000000, all `gate_en_o` bits are 0 and `fv_count_o` is 0.
- R2: A write whose data equals a valid table entry sets `gate_en_o[addr]` to 1 from the next cycle. Later reads of that address return the table value with `rd_fv_o` = 1.
- R3: A write whose data matches no valid entry sets `gate_en_o[addr]` to 0. Later reads return the full 32-bit word with `rd_fv_o` = 0.
- R4: When several valid entries hold the same value, the stored code is the lowest matching index. A later change to that entry's value changes what the word reads back as.
- R5: A table entry written with `tbl_valid_i` = 0 never matches.
- R6: Table writes while `table_lock_i` = 1 are ignored.
- R7: Read data appears on `rd_data_o` in the cycle after `rd_en_i` for both frequent and full words. It holds its value while `rd_en_i` is low.
- R8: A read and a write to the same address in the same cycle return the data stored before the write.
- R9: A rewrite to a full word clears `gate_en_o` in the same cycle the high slice is written. A read of an encoded word never depends on stale high-slice contents.
- R10: `fv_count_o` equals the number of set `gate_en_o` bits. It never exceeds DEPTH. Rewriting an already-encoded word with a frequent value does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| table_lock_i | input | 1 | Blocks table writes when high |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_idx_i | input | CODE_W | Table entry index |
| tbl_val_i | input | 32 | Table entry value |
| tbl_valid_i | input | 1 | Valid bit stored with the entry |
| wr_en_i | input | 1 | Word write strobe |
| wr_addr_i | input | ADDR_W | Word write address |
| wr_data_i | input | 32 | Word write data |
| rd_en_i | input | 1 | Word read strobe |
| rd_addr_i | input | ADDR_W | Word read address |
| rd_data_o | output | 32 | Read data, one cycle after rd_en_i |
| rd_fv_o | output | 1 | Last read word was held in encoded form |
| gate_en_o | output | DEPTH | Per-word high-slice power-gate enable |
| fv_count_o | output | CNT_W | Number of words held in encoded form |

## Verification
The bench rewrites one address from an encoded word to a full word and back. A design that read the stale high slice, or that left the gate bit set, would return a corrupted value. It stores a value that is held in two table slots, then changes the lower slot. A design that coded to the higher slot would still return the old value. It also writes the table while it is locked and writes an entry marked invalid. A design that honoured either write would gate a word that has to stay whole. It fills the array twice with frequent words and once with full words. A miscounting counter would double count, wrap, or underflow.

// File: rtl/fv_pkg.sv
package fv_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LO_W   = 5;
  localparam int unsigned HI_W   = WORD_W - LO_W;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fv_table.sv
module fv_table #(
  parameter int unsigned NUM_FV = 32,
  localparam int unsigned CODE_W = $clog2(NUM_FV)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  lock_i,
  input  logic                                  we_i,
  input  logic [CODE_W-1:0]                     idx_i,
  input  fv_pkg::word_t                         val_i,
  input  logic                                  valid_i,
  output logic [NUM_FV-1:0][fv_pkg::WORD_W-1:0] val_o,
  output logic [NUM_FV-1:0]                     vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o <= '0;
      vld_o <= '0;
    end else if (we_i && !lock_i) begin
      val_o[idx_i] <= val_i;
      vld_o[idx_i] <= valid_i;
    end
  end
endmodule

// File: rtl/fv_match.sv
module fv_match #(
  parameter int unsigned NUM_FV = 32,
  localparam int unsigned CODE_W = $clog2(NUM_FV)
) (
  input  fv_pkg::word_t                         data_i,
  input  logic [NUM_FV-1:0][fv_pkg::WORD_W-1:0] val_i,
  input  logic [NUM_FV-1:0]                     vld_i,
  output logic                                  hit_o,
  output logic [CODE_W-1:0]                     code_o
);
  logic [NUM_FV-1:0] eq;

  for (genvar g = 0; g < NUM_FV; g++) begin : g_cmp
    assign eq[g] = vld_i[g] && (val_i[g] == data_i);
  end

  // descending scan so the lowest matching index wins
  always_comb begin
    code_o = '0;
    for (int i = NUM_FV - 1; i >= 0; i--) begin
      if (eq[i]) code_o = CODE_W'(i);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/fv_word_array.sv
module fv_word_array #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned NUM_FV = 32,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CODE_W = $clog2(NUM_FV)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  wr_en_i,
  input  logic [ADDR_W-1:0]                     wr_addr_i,
  input  fv_pkg::word_t                         wr_data_i,
  input  logic                                  wr_hit_i,
  input  logic [CODE_W-1:0]                     wr_code_i,
  input  logic                                  rd_en_i,
  input  logic [ADDR_W-1:0]                     rd_addr_i,
  input  logic [NUM_FV-1:0][fv_pkg::WORD_W-1:0] tbl_val_i,
  output fv_pkg::word_t                         rd_data_o,
  output logic                                  rd_fv_o,
  output logic [DEPTH-1:0]                      gate_en_o
);
  import fv_pkg::*;

  logic [DEPTH-1:0][LO_W-1:0] lo_q;
  logic [DEPTH-1:0][HI_W-1:0] hi_q;
  logic [DEPTH-1:0]           raw_q;  // 1: full word, 0: encoded

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      raw_q <= '1;
    end else if (wr_en_i) begin
      raw_q[wr_addr_i] <= !wr_hit_i;
      if (wr_hit_i) begin
        lo_q[wr_addr_i] <= LO_W'(wr_code_i);
      end else begin
        lo_q[wr_addr_i] <= wr_data_i[LO_W-1:0];
        hi_q[wr_addr_i] <= wr_data_i[WORD_W-1:LO_W];
      end
    end
  end

  logic [CODE_W-1:0] rd_code;
  assign rd_code = lo_q[rd_addr_i][CODE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      rd_fv_o   <= 1'b0;
    end else if (rd_en_i) begin
      rd_fv_o   <= !raw_q[rd_addr_i];
      rd_data_o <= raw_q[rd_addr_i] ? {hi_q[rd_addr_i], lo_q[rd_addr_i]}
                                    : tbl_val_i[rd_code];
    end
  end

  assign gate_en_o = ~raw_q;
endmodule

// File: rtl/fv_word_store.sv
module fv_word_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned NUM_FV = 32,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CODE_W = $clog2(NUM_FV),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              table_lock_i,
  input  logic              tbl_we_i,
  input  logic [CODE_W-1:0] tbl_idx_i,
  input  logic [31:0]       tbl_val_i,
  input  logic              tbl_valid_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              rd_fv_o,
  output logic [DEPTH-1:0]  gate_en_o,
  output logic [CNT_W-1:0]  fv_count_o
);
  logic [NUM_FV-1:0][31:0] tbl_val;
  logic [NUM_FV-1:0]       tbl_vld;
  logic                    wr_hit;
  logic [CODE_W-1:0]       wr_code;

  fv_table #(.NUM_FV(NUM_FV)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (table_lock_i),
    .we_i    (tbl_we_i),
    .idx_i   (tbl_idx_i),
    .val_i   (tbl_val_i),
    .valid_i (tbl_valid_i),
    .val_o   (tbl_val),
    .vld_o   (tbl_vld)
  );

  fv_match #(.NUM_FV(NUM_FV)) u_match (
    .data_i (wr_data_i),
    .val_i  (tbl_val),
    .vld_i  (tbl_vld),
    .hit_o  (wr_hit),
    .code_o (wr_code)
  );

  fv_word_array #(.DEPTH(DEPTH), .NUM_FV(NUM_FV)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wr_hit_i  (wr_hit),
    .wr_code_i (wr_code),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .tbl_val_i (tbl_val),
    .rd_data_o (rd_data_o),
    .rd_fv_o   (rd_fv_o),
    .gate_en_o (gate_en_o)
  );

  // incremental count, saturating at both ends
  logic was_fv;
  assign was_fv = gate_en_o[wr_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fv_count_o <= '0;
    end else if (wr_en_i) begin
      if (wr_hit && !was_fv && fv_count_o != CNT_W'(DEPTH))
        fv_count_o <= fv_count_o + 1'b1;
      else if (!wr_hit && was_fv && fv_count_o != '0)
        fv_count_o <= fv_count_o - 1'b1;
    end
  end
endmodule

// File: rtl/fv_word_store_chk.sv
module fv_word_store_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              wr_hit,
  input logic              rd_en_i,
  input logic [31:0]       rd_data_o,
  input logic [DEPTH-1:0]  gate_en_o,
  input logic [CNT_W-1:0]  fv_count_o
);
  // R2
  gate_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hit) |=> gate_en_o[$past(wr_addr_i)]);

  // R9
  gate_off_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hit) |=> !gate_en_o[$past(wr_addr_i)]);

  // R7
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R10
  cnt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fv_count_o == CNT_W'($countones(gate_en_o)));

  // R10
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(fv_count_o) && $stable(gate_en_o)));
endmodule

bind fv_word_store fv_word_store_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_hit     (wr_hit),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .gate_en_o  (gate_en_o),
  .fv_count_o (fv_count_o)
);

// File: tb/fv_word_store_bench.sv
module fv_word_store_bench;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned NUM_FV = 32;
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned CODE_W = $clog2(NUM_FV);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic table_lock_i = 1'b0;
  logic tbl_we_i = 1'b0;
  logic [CODE_W-1:0] tbl_idx_i = '0;
  logic [31:0] tbl_val_i = '0;
  logic tbl_valid_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic rd_en_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic rd_fv_o;
  logic [DEPTH-1:0] gate_en_o;
  logic [CNT_W-1:0] fv_count_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fv_word_store #(.DEPTH(DEPTH), .NUM_FV(NUM_FV)) u_fv_word_store (.*);

  localparam logic [31:0] FV_A = 32'hA5A5_0000;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tbl_write(int idx, logic [31:0] val, logic vld);
    @(negedge clk_i);
    tbl_we_i = 1'b1; tbl_idx_i = CODE_W'(idx); tbl_val_i = val; tbl_valid_i = vld;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = ADDR_W'(addr); wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(int addr);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_addr_i = ADDR_W'(addr);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 gate", 32'(gate_en_o), 32'h0);
    chk("R1 count", 32'(fv_count_o), 32'h0);
    rd(7);
    chk("R1 data", rd_data_o, 32'h0);
  endtask

  task automatic t_encode;
    tbl_write(3, FV_A, 1'b1);
    table_lock_i = 1'b1;
    wr(1, FV_A);
    chk("R2 gate", 32'(gate_en_o[1]), 32'h1);
    chk("R10 count", 32'(fv_count_o), 32'h1);
    rd(1);
    chk("R2 R7 data", rd_data_o, FV_A);
    chk("R2 flag", 32'(rd_fv_o), 32'h1);
  endtask

  task automatic t_raw;
    wr(2, 32'h1234_5678);
    chk("R3 gate", 32'(gate_en_o[2]), 32'h0);
    rd(2);
    chk("R3 R7 data", rd_data_o, 32'h1234_5678);
    chk("R3 flag", 32'(rd_fv_o), 32'h0);
  endtask

  task automatic t_rewrite;
    wr(1, 32'hDEAD_BEEF);
    chk("R9 gate off", 32'(gate_en_o[1]), 32'h0);
    chk("R10 count dec", 32'(fv_count_o), 32'h0);
    rd(1);
    chk("R9 raw data", rd_data_o, 32'hDEAD_BEEF);
    wr(1, FV_A);
    wr(1, FV_A);
    chk("R10 no double", 32'(fv_count_o), 32'h1);
    rd(1);
    chk("R9 stale hi ignored", rd_data_o, FV_A);
  endtask

  task automatic t_hold;
    repeat (4) @(negedge clk_i);
    chk("R7 hold", rd_data_o, FV_A);
  endtask

  task automatic t_lock;
    tbl_write(7, 32'h0000_0777, 1'b1);
    wr(3, 32'h0000_0777);
    chk("R6 locked write ignored", 32'(gate_en_o[3]), 32'h0);
    tbl_write(3, 32'h0000_0333, 1'b1);
    rd(1);
    chk("R6 entry kept", rd_data_o, FV_A);
  endtask

  task automatic t_invalid;
    table_lock_i = 1'b0;
    tbl_write(8, 32'h0000_0888, 1'b0);
    table_lock_i = 1'b1;
    wr(4, 32'h0000_0888);
    chk("R5 invalid no match", 32'(gate_en_o[4]), 32'h0);
  endtask

  task automatic t_dup;
    table_lock_i = 1'b0;
    tbl_write(12, 32'hCAFE_0000, 1'b1);
    tbl_write(10, 32'hCAFE_0000, 1'b1);
    table_lock_i = 1'b1;
    wr(5, 32'hCAFE_0000);
    chk("R4 gate", 32'(gate_en_o[5]), 32'h1);
    table_lock_i = 1'b0;
    tbl_write(10, 32'h1111_0000, 1'b1);
    table_lock_i = 1'b1;
    rd(5);
    chk("R4 lowest index", rd_data_o, 32'h1111_0000);
  endtask

  task automatic t_collide;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 2; wr_data_i = 32'h0BAD_F00D;
    rd_en_i = 1'b1; rd_addr_i = 2;
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    chk("R8 old data", rd_data_o, 32'h1234_5678);
    rd(2);
    chk("R8 new data", rd_data_o, 32'h0BAD_F00D);
  endtask

  task automatic t_fill;
    for (int a = 0; a < DEPTH; a++) wr(a, FV_A);
    chk("R10 full", 32'(fv_count_o), 32'(DEPTH));
    chk("R10 all gated", 32'(gate_en_o), 32'(16'hFFFF));
    for (int a = 0; a < DEPTH; a++) wr(a, FV_A);
    chk("R10 saturate", 32'(fv_count_o), 32'(DEPTH));
    for (int a = 0; a < DEPTH; a++) wr(a, 32'h5000_0000 + 32'(a));
    chk("R10 empty", 32'(fv_count_o), 32'h0);
    chk("R9 none gated", 32'(gate_en_o), 32'h0);
    rd(9);
    chk("R3 raw after fill", rd_data_o, 32'h5000_0009);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_encode;
    t_raw;
    t_rewrite;
    t_hold;
    t_lock;
    t_invalid;
    t_dup;
    t_collide;
    t_fill;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule